// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block collects six interrupt sources: two external inputs, three timer overflows and the serial port. It decides which of them, if any, may interrupt the code that is running now. An enable register masks each source and also carries a master enable. A priority register places each source at either the low or the high level. Within one level, a fixed polling order breaks ties. The winning source sets the service level it runs at and selects a fixed vector address. That address goes to the core together with a one-cycle interrupt pulse.

The block keeps one in-service bit per level. A high-level source may interrupt a low-level service. Nothing may interrupt a high-level service, and a low-level request never nests inside a low-level service. A return strobe from the core closes the innermost open service, which brings back the level that was running before it. When a vector is issued, the block pulses an acknowledge mask in the flag bit layout. The peripherals use this mask to clear flags that the hardware owns: the two timer overflow flags, and the two external flags when they are edge-triggered. The serial flags and the timer 2 flags are left for software to clear.

Flag bit layout of `flags_i` and `ack_clr_o`:
- bit 0: external 0
- bit 1: timer 0 overflow
- bit 2: external 1
- bit 3: timer 1 overflow
- bit 4: serial receive
- bit 5: serial transmit
- bit 6: timer 2 overflow
- bit 7: timer 2 external

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, the enable and priority registers read as all zero and both in-service bits are clear. No interrupt is raised, whatever flags are present. `ack_clr_o` and `vec_o` are zero.
- R2: Enable register bit 7 is the master enable. While it is 0, no request is taken.
- R3: Enable register bits 0..5 enable, in turn: external 0, timer 0, external 1, timer 1, serial, and timer 2. A source whose bit is 0 is never taken. Priority register bits 0..5 use the same source order, and a 1 selects the high level.
- R4: The source index runs 0..5 in the order given in R3. The vector of a source is 0x0003 + 8 × its index. The serial source requests when flag bit 4 or flag bit 5 is set. Timer 2 requests when flag bit 6 or flag bit 7 is set.
- R5: When several requests are pending at the same level, the one with the lowest source index wins.
- R6: When enabled requests are pending at both levels, a high-level one wins, regardless of source index.
- R7: While only a low-level service is open, an enabled high-level request is taken.
- R8: While a low-level service is open, no low-level request is taken.
- R9: While a high-level service is open, no request is taken.
- R10: A `reti_i` pulse closes the high-level service if one is open, and otherwise closes the low-level one. A low-level service that was interrupted stays open after the high-level service returns.
- R11: `ack_clr_o` pulses in the same cycle as `irq_o`. It has bit 1 set for timer 0 and bit 3 set for timer 1. It has bit 0 set for external 0 or bit 2 set for external 1 only when the matching `ext_edge_i` bit (bit 0 or bit 1) is 1. Bits 4..7 are never set.
- R12: A request that is eligible in the cycle before a clock edge shows up as a one-cycle `irq_o` pulse after that edge. `vec_o` holds the issued vector until the next one is issued. A request that is still held does not raise `irq_o` again while its level is in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| flags_i | input | 8 | Request flags, in the layout given above |
| ext_edge_i | input | 2 | External 0/1 trigger type, 1 = edge |
| en_wr_i | input | 1 | Write `wdata_i` into the enable register |
| pri_wr_i | input | 1 | Write `wdata_i` into the priority register |
| wdata_i | input | 8 | Register write data |
| reti_i | input | 1 | Return-from-interrupt strobe |
| irq_o | output | 1 | One-cycle interrupt pulse to the core |
| vec_o | output | VEC_W | Vector address of the last issued interrupt |
| ack_clr_o | output | 8 | Flag clear mask, pulsed with `irq_o` |

## Verification
The bench uses the default parameters: a 16-bit vector, base 0x0003 and stride 8. With these, every one of the six vector addresses can be compared against the literal values 0x0003 through 0x002B. The defaults also make the mapping from source index to vector fully observable at the ports. This lets the table of single-source and mixed-source patterns confirm the vector selection, the polling order and the level override. The same fixed geometry keeps the nesting sequences (low service, preemption, blocked requests, staged returns) short enough to step one cycle at a time.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

    localparam int NSRC    = 6;
    localparam int FLAG_W  = 8;
    localparam int REG_W   = 8;
    localparam int EA_BIT  = 7;
    localparam int IDX_W   = $clog2(NSRC);

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_e;

    // Fold the eight request flags into six per-source requests.
    function automatic logic [NSRC-1:0] fold_flags(input logic [FLAG_W-1:0] f);
        logic [NSRC-1:0] s;
        s[0] = f[0];
        s[1] = f[1];
        s[2] = f[2];
        s[3] = f[3];
        s[4] = f[4] | f[5];
        s[5] = f[6] | f[7];
        return s;
    endfunction

endpackage

// File: rtl/prio_irq_regs.sv
module prio_irq_regs
    import prio_irq_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_wr_i,
    input  logic              pri_wr_i,
    input  logic [REG_W-1:0]  wdata_i,
    output logic              ea_o,
    output logic [NSRC-1:0]   en_mask_o,
    output logic [NSRC-1:0]   pri_mask_o
);

    typedef struct packed {
        logic            ea;
        logic [NSRC-1:0] en;
        logic [NSRC-1:0] pri;
    } regs_s;

    regs_s regs_d, regs_q;

    logic unused_wdata;
    assign unused_wdata = wdata_i[6];

    always_comb begin
        regs_d = regs_q;
        if (en_wr_i) begin
            regs_d.ea = wdata_i[EA_BIT];
            regs_d.en = wdata_i[NSRC-1:0];
        end
        if (pri_wr_i) begin
            regs_d.pri = wdata_i[NSRC-1:0];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign ea_o       = regs_q.ea;
    assign en_mask_o  = regs_q.en;
    assign pri_mask_o = regs_q.pri;

endmodule

// File: rtl/prio_irq_pick.sv
module prio_irq_pick
    import prio_irq_pkg::*;
#(
    parameter int N   = NSRC,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req_i,
    output logic [N-1:0]  grant_o,
    output logic [IW-1:0] idx_o,
    output logic          any_o
);

    // seen[i] is set when any request below index i is pending.
    logic [N:0] seen;

    assign seen[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign grant_o[i]  = req_i[i] & ~seen[i];
        assign seen[i + 1] = seen[i] | req_i[i];
    end

    assign any_o = seen[N];

    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (grant_o[i]) begin
                idx_o = IW'(i);
            end
        end
    end

endmodule

// File: rtl/prio_irq_level.sv
module prio_irq_level
    import prio_irq_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic set_i,
    input  lvl_e set_lvl_i,
    input  logic reti_i,
    output logic ins_hi_o,
    output logic ins_lo_o
);

    typedef struct packed {
        logic hi;
        logic lo;
    } ins_s;

    ins_s ins_d, ins_q;

    always_comb begin
        logic pop_hi;
        logic pop_lo;
        pop_hi = reti_i & ins_q.hi;
        pop_lo = reti_i & ~ins_q.hi & ins_q.lo;
        ins_d.hi = (ins_q.hi & ~pop_hi) | (set_i & (set_lvl_i == LVL_HIGH));
        ins_d.lo = (ins_q.lo & ~pop_lo) | (set_i & (set_lvl_i == LVL_LOW));
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ins_q <= '0;
        end else begin
            ins_q <= ins_d;
        end
    end

    assign ins_hi_o = ins_q.hi;
    assign ins_lo_o = ins_q.lo;

    AST_LOW_SURVIVES_HI_RETURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reti_i && ins_q.hi && ins_q.lo) |=> ins_q.lo); // R10

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int VEC_W      = 16,
    parameter int VEC_BASE   = 3,
    parameter int VEC_STRIDE = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [FLAG_W-1:0] flags_i,
    input  logic [1:0]        ext_edge_i,
    input  logic              en_wr_i,
    input  logic              pri_wr_i,
    input  logic [REG_W-1:0]  wdata_i,
    input  logic              reti_i,
    output logic              irq_o,
    output logic [VEC_W-1:0]  vec_o,
    output logic [FLAG_W-1:0] ack_clr_o
);

    typedef struct packed {
        logic              irq;
        lvl_e              lvl;
        logic [VEC_W-1:0]  vec;
        logic [FLAG_W-1:0] clr;
    } out_s;

    out_s out_d, out_q;

    logic            ea;
    logic [NSRC-1:0] en_mask, pri_mask;
    logic [NSRC-1:0] qual, hi_req, lo_req;
    logic [NSRC-1:0] hi_grant, lo_grant;
    logic [IDX_W-1:0] hi_idx, lo_idx;
    logic            hi_any, lo_any;
    logic            ins_hi, ins_lo;
    logic            take_hi, take_lo, take;
    logic [IDX_W-1:0] win_idx;

    prio_irq_regs i_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .en_wr_i    (en_wr_i),
        .pri_wr_i   (pri_wr_i),
        .wdata_i    (wdata_i),
        .ea_o       (ea),
        .en_mask_o  (en_mask),
        .pri_mask_o (pri_mask)
    );

    assign qual   = fold_flags(flags_i) & en_mask & {NSRC{ea}};
    assign hi_req = qual & pri_mask;
    assign lo_req = qual & ~pri_mask;

    prio_irq_pick #(.N(NSRC)) i_pick_hi (
        .req_i   (hi_req),
        .grant_o (hi_grant),
        .idx_o   (hi_idx),
        .any_o   (hi_any)
    );

    prio_irq_pick #(.N(NSRC)) i_pick_lo (
        .req_i   (lo_req),
        .grant_o (lo_grant),
        .idx_o   (lo_idx),
        .any_o   (lo_any)
    );

    assign take_hi = hi_any & ~ins_hi;
    assign take_lo = lo_any & ~hi_any & ~ins_hi & ~ins_lo;
    assign take    = take_hi | take_lo;
    assign win_idx = take_hi ? hi_idx : lo_idx;

    prio_irq_level i_level (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .set_i     (take),
        .set_lvl_i (take_hi ? LVL_HIGH : LVL_LOW),
        .reti_i    (reti_i),
        .ins_hi_o  (ins_hi),
        .ins_lo_o  (ins_lo)
    );

    always_comb begin
        out_d     = out_q;
        out_d.irq = take;
        out_d.clr = '0;
        if (take) begin
            out_d.lvl = take_hi ? LVL_HIGH : LVL_LOW;
            out_d.vec = VEC_W'(VEC_BASE + int'(win_idx) * VEC_STRIDE);
            case (win_idx)
                IDX_W'(0): out_d.clr[0] = ext_edge_i[0];
                IDX_W'(1): out_d.clr[1] = 1'b1;
                IDX_W'(2): out_d.clr[2] = ext_edge_i[1];
                IDX_W'(3): out_d.clr[3] = 1'b1;
                default:   out_d.clr    = '0;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            out_q <= '{irq: 1'b0, lvl: LVL_LOW, vec: '0, clr: '0};
        end else begin
            out_q <= out_d;
        end
    end

    assign irq_o     = out_q.irq;
    assign vec_o     = out_q.vec;
    assign ack_clr_o = out_q.clr;

    AST_MASTER_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ea |=> !irq_o); // R2
    AST_HI_SERVICE_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ins_hi |=> !irq_o); // R9
    AST_LOW_NO_NEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ins_lo |=> (!irq_o || out_q.lvl == LVL_HIGH)); // R8
    AST_ACK_WITH_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_clr_o != '0) |-> (irq_o && ack_clr_o[7:4] == 4'h0)); // R11
    AST_TAKE_MARKS_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_o && out_q.lvl == LVL_HIGH) |-> ins_hi); // R10
    AST_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(hi_grant) && $onehot0(lo_grant)); // R5

endmodule

// File: tb/test_prio_irq_ctrl.sv
`timescale 1ns/1ps
module test_prio_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  flags = 8'h00;
    logic [1:0]  edge_m = 2'b00;
    logic        en_wr = 1'b0;
    logic        pri_wr = 1'b0;
    logic [7:0]  wdata = 8'h00;
    logic        reti = 1'b0;
    logic        irq;
    logic [15:0] vec;
    logic [7:0]  ack;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    prio_irq_ctrl i_prio_irq_ctrl (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .flags_i    (flags),
        .ext_edge_i (edge_m),
        .en_wr_i    (en_wr),
        .pri_wr_i   (pri_wr),
        .wdata_i    (wdata),
        .reti_i     (reti),
        .irq_o      (irq),
        .vec_o      (vec),
        .ack_clr_o  (ack)
    );

    // Row: [50:43] enable, [42:35] priority, [34:27] flags, [26:25] edge,
    //      [24] irq expected, [23:8] vector expected, [7:0] ack expected
    localparam int NROW = 18;
    localparam logic [50:0] TBL [NROW] = '{
        {8'h3F, 8'h00, 8'h01, 2'b01, 1'b0, 16'h0000, 8'h00},
        {8'hBE, 8'h00, 8'h01, 2'b01, 1'b0, 16'h0000, 8'h00},
        {8'h84, 8'h00, 8'hFB, 2'b11, 1'b0, 16'h0000, 8'h00},
        {8'h84, 8'h00, 8'hFF, 2'b11, 1'b1, 16'h0013, 8'h04},
        {8'hBF, 8'h00, 8'h01, 2'b01, 1'b1, 16'h0003, 8'h01},
        {8'hBF, 8'h00, 8'h02, 2'b00, 1'b1, 16'h000B, 8'h02},
        {8'hBF, 8'h00, 8'h04, 2'b00, 1'b1, 16'h0013, 8'h00},
        {8'hBF, 8'h00, 8'h08, 2'b00, 1'b1, 16'h001B, 8'h08},
        {8'hBF, 8'h00, 8'h20, 2'b00, 1'b1, 16'h0023, 8'h00},
        {8'hBF, 8'h00, 8'h80, 2'b00, 1'b1, 16'h002B, 8'h00},
        {8'hBF, 8'h00, 8'h10, 2'b00, 1'b1, 16'h0023, 8'h00},
        {8'hBF, 8'h00, 8'h40, 2'b00, 1'b1, 16'h002B, 8'h00},
        {8'hBF, 8'h00, 8'hFF, 2'b11, 1'b1, 16'h0003, 8'h01},
        {8'hBF, 8'h00, 8'hFE, 2'b11, 1'b1, 16'h000B, 8'h02},
        {8'hBF, 8'h00, 8'h50, 2'b00, 1'b1, 16'h0023, 8'h00},
        {8'hBF, 8'h20, 8'hFF, 2'b00, 1'b1, 16'h002B, 8'h00},
        {8'hBF, 8'h08, 8'h0A, 2'b00, 1'b1, 16'h001B, 8'h08},
        {8'hBF, 8'h3F, 8'h0C, 2'b11, 1'b1, 16'h0013, 8'h04}
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_en(input logic [7:0] v);
        en_wr = 1'b1; wdata = v;
        step();
        en_wr = 1'b0;
    endtask

    task automatic wr_pri(input logic [7:0] v);
        pri_wr = 1'b1; wdata = v;
        step();
        pri_wr = 1'b0;
    endtask

    task automatic idle();
        flags = 8'h00; reti = 1'b1;
        step();
        step();
        reti = 1'b0;
        step();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        string row_tag [NROW];
        row_tag = '{"R2", "R3", "R3", "R3", "R4 R11", "R4 R11", "R11", "R4 R11",
                    "R4", "R4", "R4", "R4", "R5", "R5", "R5", "R6", "R6", "R11"};

        // R1: reset state with every flag raised
        flags = 8'hFF;
        edge_m = 2'b11;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        chk("R1 irq after reset", irq, 0);
        chk("R1 ack after reset", ack, 0);
        chk("R1 vec after reset", vec, 0);
        step();
        chk("R1 irq with regs cleared", irq, 0);
        idle();

        // Table of single-cycle decisions
        for (int r = 0; r < NROW; r++) begin
            wr_en(TBL[r][50:43]);
            wr_pri(TBL[r][42:35]);
            edge_m = TBL[r][26:25];
            flags  = TBL[r][34:27];
            step();
            chk({row_tag[r], " irq"}, irq, TBL[r][24]);
            chk({row_tag[r], " ack"}, ack, TBL[r][7:0]);
            if (TBL[r][24]) begin
                chk({row_tag[r], " vec"}, vec, TBL[r][23:8]);
            end
            idle();
        end

        // Nesting sequence: timer 0 high, all others low
        wr_en(8'hBF);
        wr_pri(8'h02);
        edge_m = 2'b11;
        flags = 8'h01;
        step();
        chk("R12 low take irq", irq, 1);
        chk("R12 low take vec", vec, 16'h0003);
        step();
        chk("R12 single pulse while held", irq, 0);
        chk("R12 vec held", vec, 16'h0003);
        flags = 8'h03;
        step();
        chk("R7 preempt irq", irq, 1);
        chk("R7 preempt vec", vec, 16'h000B);
        chk("R7 preempt ack", ack, 8'h02);
        step();
        chk("R9 no re-take in high service", irq, 0);
        wr_pri(8'h0A);
        flags = 8'h0B;
        step();
        chk("R9 other high blocked", irq, 0);
        step();
        chk("R9 still blocked", irq, 0);
        flags = 8'h00; reti = 1'b1;
        step();
        reti = 1'b0;
        flags = 8'h10;
        step();
        chk("R10 low still in service after first return", irq, 0);
        flags = 8'h14;
        step();
        chk("R8 low request blocked in low service", irq, 0);
        flags = 8'h10; reti = 1'b1;
        step();
        reti = 1'b0;
        step();
        chk("R10 low taken after second return", irq, 1);
        chk("R10 vec after second return", vec, 16'h0023);
        chk("R11 no ack for serial", ack, 0);
        idle();

        // R2: clearing master enable blocks a pending request
        wr_en(8'h3F);
        flags = 8'h02;
        step();
        step();
        chk("R2 master off blocks timer 0", irq, 0);
        idle();

        finish_run();
    end

endmodule